// File: doc/BRIEF.md
# MDIO management frame controller

This block is the master side of a two-wire PHY management link. Software loads a complete 32-bit management frame, already encoded, into a single command/data register. Writing that register starts a transaction. The block first sends a run of ones, then shifts the frame out most significant bit first on the data line. It generates the management clock from the system clock.

On a read frame the block stops driving the data line during the turnaround. It then collects the sixteen data bits that the PHY returns and places them in the low half of the same register. The upper half keeps the command.

When the frame is finished, a sticky event bit is set. Software polls that bit and clears it by writing a one to it. The management clock rate comes from a programmable divisor. A divisor of zero keeps the link idle.

Top module: `mdio_master`

## Requirements
- R1: After reset the management clock and the data-line enable are low, and the command/data register (select 0), event register (select 1) and divisor register (select 2) all read zero.
- R2: A started transaction sends 32 ones and then the 32 bits of the command register, most significant bit first. One bit goes out per management clock period. Each bit is launched while the clock is low and is stable at its rising edge.
- R3: With divisor value S, the management clock is high for S system cycles and low for S system cycles. The event bit becomes visible exactly 128*S cycles after the clock edge that accepted the command.
- R4: A frame whose bits 29:28 are not 2'b10 keeps the data line driven for all 64 bit times. It leaves the command/data register unchanged.
- R5: A frame whose bits 29:28 equal 2'b10 is a read. The data line is released from frame bit 16 (the second turnaround bit) to the end. The sixteen bits sampled at the clock rising edges of frame bits 15..0 are stored, MSB first, into register bits 15:0. Bits 31:16 keep the command.
- R6: A read during which no PHY drives the line (the line idles high) returns 16'hFFFF in bits 15:0.
- R7: Completion sets event register bit 23. Writing select 1 with bit 23 set clears it. A write with bit 23 clear has no effect. A completion in the same cycle as a clear leaves it set.
- R8: A write to select 0 while a transaction is in progress is ignored. The frame on the line and the register contents stay those of the running transaction.
- R9: While the divisor register is zero, a write to select 0 is ignored. No transaction starts, the clock stays low, and no event is raised.
- R10: The divisor register holds the low SPEED_W bits written to select 2 and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 command/data, 1 event, 2 divisor |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe_o | output | 1 | Enable for the management data driver |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The bench builds the block with its defaults: a 6-bit divisor, a 32-bit preamble, and the event at bit 23. It drives divisors of 1 to 4. Because each 64-bit frame then takes only 128 to 512 cycles, read frames can be swept over all 32 PHY addresses with arithmetically derived register numbers and PHY return values. Each frame's 64 bits, its driver enable, and the clock's high and low times are checked against a model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      SEL_DATA  = 2'd0,
      SEL_EVENT = 2'd1,
      SEL_SPEED = 2'd2
   } mdio_sel_e;

   // Frame layout fields the serializer decodes
   localparam int FRAME_W  = 32;
   localparam int RDATA_W  = 16;
   localparam int OP_HI    = 29;
   localparam int TA_LO    = 16;
   localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int SPEED_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               run,
   input  logic [SPEED_W-1:0] div,
   output logic               mdc,
   output logic               rise_tick,
   output logic               fall_tick
);
   if (SPEED_W < 1 || SPEED_W > 16) begin : g_bad_speed_w
      $error("mdio_clkdiv: SPEED_W out of range");
   end

   logic [SPEED_W-1:0] div_q;
   logic [SPEED_W-1:0] cnt;
   logic               wrap;

   assign wrap      = run && (cnt == div_q - SPEED_W'(1));
   assign rise_tick = wrap && !mdc;
   assign fall_tick = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt   <= '0;
         mdc   <= 1'b0;
      end else if (start) begin
         div_q <= div;
         cnt   <= '0;
         mdc   <= 1'b0;
      end else if (run) begin
         if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
         end else begin
            cnt <= cnt + SPEED_W'(1);
         end
      end else begin
         cnt <= '0;
         mdc <= 1'b0;
      end
   end

   // R1 / R9: clock rests low whenever no frame runs
   a_r1_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mdc);

   // R3: clock holds its level between divider wraps
   a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap && !start) |=> (mdc == $past(mdc)));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
   parameter int PRE_LEN = 32,
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 16,
   parameter int TA_LO   = 16,
   parameter int OP_HI   = 29
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] cmd,
   input  logic               rise_tick,
   input  logic               fall_tick,
   input  logic               mdio_i,
   output logic               busy,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int TOTAL = PRE_LEN + FRAME_W;
   localparam int IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] REL_I  = IDX_W'(PRE_LEN + FRAME_W - 1 - TA_LO);
   localparam logic [IDX_W-1:0] DPH_I  = IDX_W'(TOTAL - DATA_W);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_shifter: preamble must be at least one bit");
   end
   if (DATA_W > TA_LO || TA_LO >= FRAME_W) begin : g_bad_layout
      $error("mdio_shifter: data field must sit below the turnaround");
   end
   if (OP_HI < 1 || OP_HI >= FRAME_W) begin : g_bad_op
      $error("mdio_shifter: opcode position outside frame");
   end

   logic               busy_q;
   logic               is_rd_q;
   logic [IDX_W-1:0]   idx;
   logic [FRAME_W-1:0] sr;
   logic [DATA_W-1:0]  rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
         idx     <= '0;
         sr      <= '0;
         rsh     <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         is_rd_q <= (cmd[OP_HI -: 2] == mdio_pkg::OP_READ);
         idx     <= '0;
         sr      <= cmd;
         rsh     <= '0;
      end else if (busy_q) begin
         if (rise_tick && is_rd_q && idx >= DPH_I) begin
            rsh <= {rsh[DATA_W-2:0], mdio_i};
         end
         if (fall_tick) begin
            if (idx == LAST_I) begin
               busy_q <= 1'b0;
            end else begin
               idx <= idx + IDX_W'(1);
               if (idx >= PRE_I) begin
                  sr <= {sr[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = busy_q && fall_tick && (idx == LAST_I);
   assign rd_data = rsh;

   always_comb begin
      if (!busy_q || idx < PRE_I) begin
         mdio_o = 1'b1;
      end else begin
         mdio_o = sr[FRAME_W-1];
      end
   end

   assign mdio_oe = busy_q && !(is_rd_q && idx >= REL_I);

   // R2: preamble bits are driven ones
   a_r2_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && idx < PRE_I) |-> (mdio_o && mdio_oe));

   // R4: a non-read frame never lets go of the line
   a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !is_rd_q) |-> mdio_oe);

   // R5: the line is let go only by a read, at the second turnaround bit
   a_r5_release_point: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $fell(mdio_oe)) |-> (is_rd_q && idx == REL_I));

   // R2: bit index advances only on a falling clock edge
   a_r2_index_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall_tick) |=> $stable(idx));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int SPEED_W = 6,
   parameter int PRE_LEN = 32,
   parameter int EVT_BIT = 23
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        mdc_o,
   output logic        mdio_o,
   output logic        mdio_oe_o,
   input  logic        mdio_i
);
   import mdio_pkg::*;

   if (EVT_BIT < 0 || EVT_BIT > 31) begin : g_bad_evt
      $error("mdio_master: EVT_BIT outside register");
   end
   if (SPEED_W < 1 || SPEED_W > 16) begin : g_bad_spd
      $error("mdio_master: SPEED_W out of range");
   end

   logic [FRAME_W-1:0] data_q;
   logic               evt_q;
   logic [SPEED_W-1:0] spd_q;
   logic               busy;
   logic               done;
   logic               go;
   logic               rise_tick;
   logic               fall_tick;
   logic [RDATA_W-1:0] rd_data;
   logic               sel_data;
   logic               sel_evt;
   logic               sel_spd;

   assign sel_data = (cfg_sel == SEL_DATA);
   assign sel_evt  = (cfg_sel == SEL_EVENT);
   assign sel_spd  = (cfg_sel == SEL_SPEED);
   assign go       = cfg_we && sel_data && !busy && (spd_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         evt_q  <= 1'b0;
         spd_q  <= '0;
      end else begin
         if (go) begin
            data_q <= cfg_wdata;
         end else if (done && data_q[OP_HI -: 2] == OP_READ) begin
            data_q[RDATA_W-1:0] <= rd_data;
         end
         if (done) begin
            evt_q <= 1'b1;
         end else if (cfg_we && sel_evt && cfg_wdata[EVT_BIT]) begin
            evt_q <= 1'b0;
         end
         if (cfg_we && sel_spd) begin
            spd_q <= cfg_wdata[SPEED_W-1:0];
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (sel_data) begin
         cfg_rdata = data_q;
      end else if (sel_evt) begin
         cfg_rdata[EVT_BIT] = evt_q;
      end else if (sel_spd) begin
         cfg_rdata[SPEED_W-1:0] = spd_q;
      end
   end

   mdio_clkdiv #(
      .SPEED_W (SPEED_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go),
      .run       (busy),
      .div       (spd_q),
      .mdc       (mdc_o),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_shifter #(
      .PRE_LEN (PRE_LEN),
      .FRAME_W (FRAME_W),
      .DATA_W  (RDATA_W),
      .TA_LO   (TA_LO),
      .OP_HI   (OP_HI)
   ) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go),
      .cmd       (cfg_wdata),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe_o),
      .done      (done),
      .rd_data   (rd_data)
   );

   // R7: the event only appears at the end of a frame
   a_r7_event_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q) |-> $past(done));

   // R8: register holds while a frame is on the line
   a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(data_q));

   // R9: a zero divisor never starts a frame
   a_r9_zero_speed: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sel_data && !busy && spd_q == '0) |=> !busy);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SPEED_W    = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_master #(.SPEED_W(SPEED_W)) u_mdio_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .mdc_o     (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe_o (mdio_oe),
      .mdio_i    (mdio_i)
   );

   // PHY model: records each bit at the clock rise, answers reads
   int          cap_n = 0;
   logic [63:0] cap_o;
   logic [63:0] cap_oe;
   logic        phy_on = 1'b0;
   logic [15:0] phy_val = '0;
   logic        phy_bit;

   always @(posedge mdc) begin
      if (cap_n < 64) begin
         cap_o[63-cap_n]  = mdio_o;
         cap_oe[63-cap_n] = mdio_oe;
         cap_n = cap_n + 1;
      end
   end

   always_comb begin
      if (phy_on && cap_n >= 48 && cap_n < 64) phy_bit = phy_val[63-cap_n];
      else phy_bit = 1'b1;
   end
   assign mdio_i = mdio_oe ? mdio_o : phy_bit;

   // Clock run-length tracker
   logic prev_mdc = 1'b0;
   int   run_len = 0;
   int   hi_bad = 0;
   int   lo_bad = 0;
   int   exp_s = 1;
   logic first_lo = 1'b1;
   logic mdc_seen_hi = 1'b0;

   always @(negedge clk) begin
      if (mdc === 1'b1) mdc_seen_hi = 1'b1;
      if (mdc === prev_mdc) begin
         run_len = run_len + 1;
      end else begin
         if (prev_mdc) begin
            if (run_len != exp_s) hi_bad = hi_bad + 1;
         end else if (!first_lo) begin
            if (run_len != exp_s) lo_bad = lo_bad + 1;
         end else begin
            first_lo = 1'b0;
         end
         run_len = 1;
      end
      prev_mdc = mdc;
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog (all requirements) act=%0d exp<=150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      cfg_sel = sel;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [31:0] rd_cmd(input int a, input int r);
      return 32'h6002_0000 | (32'(a & 31) << 23) | (32'(r & 31) << 18);
   endfunction

   function automatic logic [31:0] wr_cmd(input int a, input int r, input logic [15:0] v);
      return 32'h5002_0000 | (32'(a & 31) << 23) | (32'(r & 31) << 18) | 32'(v);
   endfunction

   task automatic arm(input int s, input logic on, input logic [15:0] v);
      logic [31:0] r;
      rd(2'd2, r);
      if (r != 32'(s)) wr(2'd2, 32'(s));
      exp_s = s; hi_bad = 0; lo_bad = 0; first_lo = 1'b1;
      cap_n = 0; phy_on = on; phy_val = v;
   endtask

   task automatic wait_evt(output int lat);
      logic [31:0] r;
      lat = 0;
      rd(2'd1, r);
      while (r[23] == 1'b0 && lat < 5000) begin
         @(negedge clk);
         lat = lat + 1;
         rd(2'd1, r);
      end
   endtask

   task automatic check_frame(input logic [31:0] cmd, input logic on, input logic [15:0] v);
      logic        is_rd;
      logic [63:0] exp_o;
      logic [63:0] exp_oe;
      logic [31:0] d;
      logic [31:0] exp_d;
      is_rd  = (cmd[29:28] == 2'b10);
      exp_o  = {32'hFFFF_FFFF, cmd};
      exp_oe = is_rd ? ~((64'd1 << 17) - 64'd1) : ~64'd0;
      chk(cap_n == 64, "R2 bit count", 64'(cap_n), 64'd64);
      chk((cap_o & exp_oe) == (exp_o & exp_oe), "R2 frame bits", cap_o & exp_oe, exp_o & exp_oe);
      chk(cap_oe == exp_oe, is_rd ? "R5 release pattern" : "R4 driven pattern", cap_oe, exp_oe);
      chk(hi_bad == 0 && lo_bad == 0, "R3 clock high/low times", 64'(hi_bad + lo_bad), 64'd0);
      rd(2'd0, d);
      if (is_rd) exp_d = {cmd[31:16], on ? v : 16'hFFFF};
      else exp_d = cmd;
      chk(d == exp_d, is_rd ? (on ? "R5 read data" : "R6 no-PHY data") : "R4 register kept",
          64'(d), 64'(exp_d));
   endtask

   task automatic run_cmd(input logic [31:0] cmd, input int s, input logic on, input logic [15:0] v);
      int lat;
      logic [31:0] r;
      arm(s, on, v);
      wr(2'd0, cmd);
      wait_evt(lat);
      chk(lat == 128 * s, "R3 completion latency", 64'(lat), 64'(128 * s));
      check_frame(cmd, on, v);
      wr(2'd1, 32'h0080_0000);
      rd(2'd1, r);
      chk(r == 32'd0, "R7 event cleared", 64'(r), 64'd0);
   endtask

   initial begin
      logic [31:0] r;
      logic [31:0] c_a;
      logic [31:0] c_b;
      int lat;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
      rd(2'd0, r); chk(r == 0, "R1 data reset", 64'(r), 64'd0);
      rd(2'd1, r); chk(r == 0, "R1 event reset", 64'(r), 64'd0);
      rd(2'd2, r); chk(r == 0, "R1 divisor reset", 64'(r), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: divisor zero blocks a command
      mdc_seen_hi = 1'b0;
      wr(2'd0, rd_cmd(3, 1));
      repeat (300) @(negedge clk);
      chk(mdc_seen_hi == 1'b0, "R9 clock stays low", 64'(mdc_seen_hi), 64'd0);
      rd(2'd1, r); chk(r == 0, "R9 no event", 64'(r), 64'd0);
      rd(2'd0, r); chk(r == 0, "R9 register untouched", 64'(r), 64'd0);

      // R10: divisor register width
      wr(2'd2, 32'd5);
      rd(2'd2, r); chk(r == 32'd5, "R10 divisor readback", 64'(r), 64'd5);
      wr(2'd2, 32'hFFFF_FFC3);
      rd(2'd2, r); chk(r == 32'h03, "R10 divisor truncation", 64'(r), 64'h03);

      // Read sweep over all PHY addresses at divisor 1
      for (int a = 0; a < 32; a++) begin
         run_cmd(rd_cmd(a, (a * 7 + 3) & 31), 1, (a != 31),
                 16'((a * 16'h0841) ^ 16'hA5C3));
      end
      // Divisor sweep with writes and reads
      for (int s = 1; s <= 4; s++) begin
         run_cmd(wr_cmd(s * 5, s + 16, 16'((s * 16'h1357) ^ 16'hFF00)), s, 1'b1, 16'h0);
         run_cmd(rd_cmd(s, 31 - s), s, 1'b1, 16'(16'h8001 | (s << 4)));
      end
      run_cmd(rd_cmd(9, 2), 3, 1'b0, 16'h0);   // R6 at slower clock
      run_cmd(wr_cmd(0, 0, 16'h0000), 2, 1'b0, 16'h0);
      run_cmd(wr_cmd(31, 31, 16'hFFFF), 1, 1'b0, 16'h0);

      // R8: command during a frame ignored; R7: write of zero bit keeps event
      c_a = wr_cmd(17, 4, 16'h3C5A);
      c_b = rd_cmd(2, 9);
      arm(2, 1'b1, 16'h1234);
      wr(2'd0, c_a);
      repeat (20) @(negedge clk);
      wr(2'd0, c_b);
      wait_evt(lat);
      chk(lat > 0 && lat < 5000, "R8 first frame completes", 64'(lat), 64'(256));
      check_frame(c_a, 1'b1, 16'h1234);
      rd(2'd0, r); chk(r == c_a, "R8 second command ignored", 64'(r), 64'(c_a));
      wr(2'd1, 32'hFF7F_FFFF);
      rd(2'd1, r); chk(r == 32'h0080_0000, "R7 zero bit no effect", 64'(r), 64'h0080_0000);
      wr(2'd1, 32'h0080_0000);
      rd(2'd1, r); chk(r == 32'd0, "R7 clear", 64'(r), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule